// File: doc/BRIEF.md
# Dual-Enable One-Time-Programmable Memory

A synthesizable behavioural model of a small fuse memory: 256 words of 4 bits, chosen by an 8-bit address, read out through a registered port that is gated by two active-low chip selects. Every bit starts at the blank value 1. A fuse-burn request can permanently move a single bit to 0. The only way back to 1 is the synchronous reset, which stands in for a fresh part.

A burn request is a one-cycle `burn_req` pulse that carries a one-hot `burn_bit` mask and the word address on `addr`. The request is accepted only while the chip is deselected (either select high) and only if exactly one mask bit is set. A rejected request leaves the array unchanged and raises `burn_err` for one cycle. A small controller runs the request through three states:
- `PS_IDLE`: no request pending.
- `PS_BURN`: an accepted request. The fuse is cleared on the edge that leaves this state.
- `PS_REJECT`: a refused request. `burn_err` is high while in this state.

The transitions are taken on every edge, from any state:
- `req_ok`: a legal pulse goes to `PS_BURN`.
- `req_bad`: an illegal pulse goes to `PS_REJECT`.
- `no_req`: no pulse goes to `PS_IDLE`.

Top module: `otp_fuse_rom`

## Requirements
- R1: The array has 256 words of 4 bits. A read samples `addr` on a rising edge, and the word at that address appears on `dout` after that same edge. The latency is one cycle, and addresses 0 through 255 are all reachable.
- R2: `dout_en` is high after an edge exactly when `sel1_n` and `sel2_n` were both low at that edge. While `dout_en` is low, `dout` is 4'b0000.
- R3: After reset, every word reads 4'hF, and both `dout_en` and `burn_err` are low.
- R4: A legal burn clears bit i of the word at `addr`, where `burn_bit` bit i maps to `dout[i]`. A legal burn means: `burn_req` high, at least one select high, and exactly one bit of `burn_bit` set. A read sampled two or more edges after the request edge shows that bit as 0.
- R5: A cleared bit stays 0. Further burns of the same bit, and any reads, leave it at 0.
- R6: A request whose `burn_bit` has zero bits set, or more than one, changes no bit and raises `burn_err` in the cycle after the request edge.
- R7: A request made while both selects are low changes no bit and raises `burn_err` in the cycle after the request edge.
- R8: `burn_err` is low after any edge at which no request was presented, and after a legal request.
- R9: A burn changes no other bit of the same word and no bit of any other word.
- R10: Asserting `rst` restores every cleared bit to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; blanks the array |
| addr | input | 8 | Word address for reads and burns |
| sel1_n | input | 1 | Chip select 1, active low |
| sel2_n | input | 1 | Chip select 2, active low |
| burn_req | input | 1 | One-cycle fuse-burn request |
| burn_bit | input | 4 | One-hot mask of the data bit to burn |
| dout | output | 4 | Registered read data, zero while not driven |
| dout_en | output | 1 | High when `dout` is driven (both selects were low) |
| burn_err | output | 1 | One-cycle flag for a refused burn request |

## Verification
The main function is exercised by reading blank words at the two ends of the address range and in the middle, and by burning single bits at several addresses. After each burn the target word and its neighbours are read back, which tells a correct one-bit clear apart from one that hits a whole word or a neighbouring word. Requests with each select high in turn show that either select alone permits a burn. Illegal masks (no bits set, two bits set) and a request with both selects low must each flag an error and leave the word blank. Back-to-back burns to adjacent words and a final reset show that the pending write is tracked correctly and that the array is restored.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        PS_IDLE   = 2'd0,
        PS_BURN   = 2'd1,
        PS_REJECT = 2'd2
    } prog_state_t;

endpackage

// File: rtl/otp_prog_fsm.sv
module otp_prog_fsm
    import otp_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_on,
    input  logic              burn_req,
    input  logic [DATA_W-1:0] burn_bit,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_mask,
    output logic              burn_err
);

    prog_state_t state_q, state_d;
    logic        req_ok;

    always_comb begin
        req_ok = !chip_on && ($countones(burn_bit) == 1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE, PS_BURN, PS_REJECT: begin
                if (!burn_req)   state_d = PS_IDLE;
                else if (req_ok) state_d = PS_BURN;
                else             state_d = PS_REJECT;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_addr <= '0;
            wr_mask <= '0;
        end else if (burn_req && req_ok) begin
            wr_addr <= addr;
            wr_mask <= burn_bit;
        end
    end

    always_comb begin
        wr_en    = 1'b0;
        burn_err = 1'b0;
        unique case (state_q)
            PS_IDLE:   ;
            PS_BURN:   wr_en    = 1'b1;
            PS_REJECT: burn_err = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                words[w] <= '1;
            else if (wr_en && (wr_addr == ADDR_W'(w)))
                words[w] <= words[w] & ~wr_mask;
        end
    end

    always_comb begin
        rd_data = words[rd_addr];
    end

endmodule

// File: rtl/otp_read_port.sv
module otp_read_port #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_on,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= chip_on;
            dout    <= chip_on ? rd_data : '0;
        end
    end

endmodule

// File: rtl/otp_fuse_rom.sv
module otp_fuse_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sel1_n,
    input  logic              sel2_n,
    input  logic              burn_req,
    input  logic [DATA_W-1:0] burn_bit,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              burn_err
);

    logic              chip_on;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_mask;
    logic [DATA_W-1:0] rd_data;

    always_comb begin
        chip_on = !sel1_n && !sel2_n;
    end

    otp_prog_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .chip_on  (chip_on),
        .burn_req (burn_req),
        .burn_bit (burn_bit),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_mask  (wr_mask),
        .burn_err (burn_err)
    );

    otp_fuse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_mask (wr_mask),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    otp_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .chip_on (chip_on),
        .rd_data (rd_data),
        .dout    (dout),
        .dout_en (dout_en)
    );

endmodule

// File: rtl/otp_fuse_rom_chk.sv
module otp_fuse_rom_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              sel1_n,
    input logic              sel2_n,
    input logic              burn_req,
    input logic [DATA_W-1:0] burn_bit,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              burn_err
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!dout_en && !burn_err));                                        // R3

    AST_EN_TRACKS_SEL: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (dout_en == $past(!sel1_n && !sel2_n)));                     // R2

    AST_OFF_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));                                              // R2

    AST_BAD_MASK_FLAG: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(burn_req) && ($countones($past(burn_bit)) != 1))
            |-> burn_err);                                                       // R6

    AST_SELECTED_FLAG: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(burn_req && !sel1_n && !sel2_n)) |-> burn_err);         // R7

    AST_NO_REQ_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(burn_req)) |-> !burn_err);                            // R8

    AST_addr_unused_guard: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(!sel1_n && !sel2_n) && $stable(addr) && !$past(burn_req)
            && !burn_req) |-> dout_en);                                          // R1

endmodule

bind otp_fuse_rom otp_fuse_rom_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .sel1_n   (sel1_n),
    .sel2_n   (sel2_n),
    .burn_req (burn_req),
    .burn_bit (burn_bit),
    .dout     (dout),
    .dout_en  (dout_en),
    .burn_err (burn_err)
);

// File: tb/otp_fuse_rom_tb.sv
`timescale 1ns/1ps
module otp_fuse_rom_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = '0;
    logic       sel1_n = 1'b1;
    logic       sel2_n = 1'b1;
    logic       burn_req = 1'b0;
    logic [3:0] burn_bit = '0;
    logic [3:0] dout;
    logic       dout_en;
    logic       burn_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    otp_fuse_rom u_dut (
        .clk(clk), .rst(rst), .addr(addr), .sel1_n(sel1_n), .sel2_n(sel2_n),
        .burn_req(burn_req), .burn_bit(burn_bit),
        .dout(dout), .dout_en(dout_en), .burn_err(burn_err)
    );

    // behavioural reference model
    logic [3:0] m_mem [256];
    logic [3:0] e_dout = '0;
    logic       e_en = 1'b0;
    logic       e_err = 1'b0;
    bit         p_valid = 1'b0;
    int         p_addr = 0;
    logic [3:0] p_mask = '0;
    bit         m_live = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 4'hF;
            e_dout = '0; e_en = 1'b0; e_err = 1'b0; p_valid = 1'b0;
            m_live = 1'b1;
        end else begin
            bit on;
            bit legal;
            on     = !sel1_n && !sel2_n;
            e_en   = on;
            e_dout = on ? m_mem[addr] : 4'h0;
            if (p_valid) m_mem[p_addr] = m_mem[p_addr] & ~p_mask;
            legal   = !on && ($countones(burn_bit) == 1);
            p_valid = burn_req && legal;
            p_addr  = addr;
            p_mask  = burn_bit;
            e_err   = burn_req && !legal;
        end
    end

    always @(negedge clk) begin
        if (m_live && !done) begin
            checks++;
            if (dout !== e_dout || dout_en !== e_en || burn_err !== e_err) begin
                errors++;
                $display("FAIL R1/R2/R6 model compare: dout=%h en=%b err=%b expected dout=%h en=%b err=%b",
                         dout, dout_en, burn_err, e_dout, e_en, e_err);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] a, input logic s1, input logic s2,
                        input logic rq, input logic [3:0] m);
        addr = a; sel1_n = s1; sel2_n = s2; burn_req = rq; burn_bit = m;
        @(negedge clk);
    endtask

    task automatic read_chk(input logic [7:0] a, input logic [3:0] exp, input string tag);
        step(a, 1'b0, 1'b0, 1'b0, 4'h0);
        check(dout_en === 1'b1 && dout === exp, tag, dout, exp);
    endtask

    task automatic burn(input logic [7:0] a, input logic [3:0] m, input logic s1, input logic s2);
        step(a, s1, s2, 1'b1, m);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check(dout_en === 1'b0 && burn_err === 1'b0, "R3 reset outputs", {dout_en, burn_err}, 0);
        rst = 1'b0;
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);

        read_chk(8'd0,   4'hF, "R3 blank word 0");
        read_chk(8'd255, 4'hF, "R1 blank word 255");
        read_chk(8'd128, 4'hF, "R3 blank word 128");

        step(8'd0, 1'b1, 1'b0, 1'b0, 4'h0);
        check(dout_en === 1'b0 && dout === 4'h0, "R2 sel1 high", {dout_en, dout}, 0);
        step(8'd0, 1'b0, 1'b1, 1'b0, 4'h0);
        check(dout_en === 1'b0 && dout === 4'h0, "R2 sel2 high", {dout_en, dout}, 0);

        burn(8'd5, 4'b0100, 1'b1, 1'b0);
        check(burn_err === 1'b0, "R8 legal burn no flag", burn_err, 0);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd5, 4'hB, "R4 burn bit2 word5");
        read_chk(8'd4, 4'hF, "R9 neighbour word4");
        read_chk(8'd6, 4'hF, "R9 neighbour word6");

        burn(8'd5, 4'b0001, 1'b0, 1'b1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd5, 4'hA, "R4 burn bit0 via sel2");

        burn(8'd5, 4'b0100, 1'b1, 1'b1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd5, 4'hA, "R5 reburn stays cleared");
        read_chk(8'd5, 4'hA, "R5 repeated read");

        burn(8'd9, 4'b0011, 1'b1, 1'b1);
        check(burn_err === 1'b1, "R6 two-bit mask flag", burn_err, 1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        check(burn_err === 1'b0, "R8 flag one cycle", burn_err, 0);
        read_chk(8'd9, 4'hF, "R6 two-bit mask no change");

        burn(8'd9, 4'b0000, 1'b1, 1'b1);
        check(burn_err === 1'b1, "R6 empty mask flag", burn_err, 1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd9, 4'hF, "R6 empty mask no change");

        burn(8'd10, 4'b0010, 1'b0, 1'b0);
        check(burn_err === 1'b1, "R7 selected burn flag", burn_err, 1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd10, 4'hF, "R7 selected burn no change");

        burn(8'd20, 4'b1000, 1'b1, 1'b1);
        burn(8'd21, 4'b0001, 1'b1, 1'b1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd20, 4'h7, "R4 back-to-back first");
        read_chk(8'd21, 4'hE, "R4 back-to-back second");

        burn(8'd255, 4'b0010, 1'b1, 1'b1);
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        read_chk(8'd255, 4'hD, "R1 top address burn");
        read_chk(8'd254, 4'hF, "R9 word below top");

        rst = 1'b1;
        step(8'd0, 1'b1, 1'b1, 1'b0, 4'h0);
        rst = 1'b0;
        read_chk(8'd5,   4'hF, "R10 reset restores word5");
        read_chk(8'd255, 4'hF, "R10 reset restores word255");
        read_chk(8'd20,  4'hF, "R10 reset restores word20");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule